// File: doc/BRIEF.md
# Dirty-Plane Re-Arm Controller for Panel Self-Refresh

This block decides when a panel self-refresh engine may be armed again. Rendering logic reports planes that are about to be modified through an invalidate strobe with a plane mask. It reports planes whose update has reached memory through a flush strobe with a plane mask. Both masks are first reduced to the planes that feed the pipe in use. The block keeps a register of planes that are still dirty. It pulses an exit request whenever a relevant plane is touched, so the engine leaves self-refresh and scans out the new content.

Re-arming is never immediate. A flush that leaves no dirty plane while the engine is not active starts a delay timer, nominally 100 ms expressed in clock ticks. When that timer expires, the block waits a bounded time for the engine to report idle. It then checks once more that the feature is still enabled and that no plane has become dirty in the meantime, and only then pulses the activate request. If idle does not arrive within the bound, or the feature is switched off, the re-arm is dropped.

Top module: `fb_rearm_ctrl`

## Requirements
- R1: Plane bit i of an invalidate or flush mask takes effect only when bit i of `relevMask` is 1. A strobe whose masked bits are all zero changes no dirty state and raises no exit request.
- R2: An enabled invalidate adds its masked bits to the dirty register. If the masked bits are non-zero, `exitReq` is high for exactly the cycle after the strobe.
- R3: An enabled flush removes its masked bits from the dirty register. If the masked bits are non-zero, `exitReq` is high for the cycle after the strobe.
- R4: A flush starts the re-arm timer only when `active` is low, no timer is already running and the dirty register is empty after the flush. A flush while the timer runs does not restart it.
- R5: With `idleReady` held high, `activateReq` is a single-cycle pulse that appears DELAY_TICKS+1 cycles after the edge that sampled the starting flush.
- R6: After the delay, the block waits at most IDLE_TIMEOUT cycles for `idleReady`. If `idleReady` does not arrive in that window the re-arm is abandoned, and a later `idleReady` produces no activate.
- R7: When `idleReady` is seen, `activateReq` is issued only if the dirty register (including a same-cycle invalidate) is empty. Otherwise the re-arm is dropped.
- R8: The dirty register is held at zero while `enable` is low, so it is empty when the feature is enabled again.
- R9: Dropping `enable` cancels a running timer or idle wait, and no activate follows from it.
- R10: When invalidate and flush arrive in the same cycle, the invalidate is applied first and the flush second. A plane named by both ends clean.
- R11: While `enable` is low, strobes are ignored and neither `exitReq` nor `activateReq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Feature enabled |
| active | input | 1 | Engine currently in self-refresh |
| idleReady | input | 1 | Engine status reports idle |
| relevMask | input | PLANES | Planes belonging to the pipe in use |
| invStb | input | 1 | Invalidate strobe |
| invMask | input | PLANES | Planes being invalidated |
| flushStb | input | 1 | Flush strobe |
| flushMask | input | PLANES | Planes being flushed |
| exitReq | output | 1 | Request to leave self-refresh (pulse) |
| activateReq | output | 1 | Request to arm self-refresh (pulse) |

## Verification
`exitReq` is registered. It is due in the cycle right after the edge that samples a strobe, so the bench checks it at the first falling edge following that strobe. `activateReq` is due DELAY_TICKS+1 edges after the starting flush, or one edge after `idleReady` rises during the wait. The bench checks it low at edge DELAY_TICKS, high at DELAY_TICKS+1 and low again one edge later. Cases that must produce no activate are checked by counting pulses over a window that reaches past the latest cycle an activate could appear.

// File: rtl/fb_rearm_pkg.sv
package fb_rearm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_WAIT  = 2'd2
  } rearmState_e;

  // Strobes from the control FSM to the datapath's shared counter.
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } dpCmd_t;

endpackage

// File: rtl/fb_rearm_dp.sv
module fb_rearm_dp
  import fb_rearm_pkg::*;
#(
  parameter int PLANES = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PLANES-1:0] relevMask,
  input  logic              invStb,
  input  logic [PLANES-1:0] invMask,
  input  logic              flushStb,
  input  logic [PLANES-1:0] flushMask,
  input  dpCmd_t            cmd,
  output logic              exitReq,
  output logic              flushSeen,
  output logic              busyNextZero,
  output logic [CNT_W-1:0]  cnt
);

  logic [PLANES-1:0] busyQ;
  logic [PLANES-1:0] invHit;
  logic [PLANES-1:0] flushHit;
  logic [PLANES-1:0] busyNext;
  logic              exitQ;
  logic [CNT_W-1:0]  cntQ;

  // Restrict to the pipe's planes; nothing passes while disabled.
  assign invHit   = (invStb && enable)   ? (invMask & relevMask)   : '0;
  assign flushHit = (flushStb && enable) ? (flushMask & relevMask) : '0;

  // Invalidate lands first, flush second.
  assign busyNext     = (busyQ | invHit) & ~flushHit;
  assign busyNextZero = (busyNext == '0);
  assign flushSeen    = flushStb && enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= '0;
      exitQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      busyQ <= enable ? busyNext : '0;
      exitQ <= (|invHit) || (|flushHit);
      if (cmd.cntClr) begin
        cntQ <= '0;
      end else if (cmd.cntInc) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign exitReq = exitQ;
  assign cnt     = cntQ;

  assert_exit_on_inv_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (enable && invStb && |(invMask & relevMask)) |=> exitReq);

  assert_exit_on_flush_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (enable && flushStb && |(flushMask & relevMask)) |=> exitReq);

  assert_masked_quiet_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (!(invStb && |(invMask & relevMask)) && !(flushStb && |(flushMask & relevMask)))
    |=> !exitReq);

  assert_busy_off_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (busyQ == '0));

  assert_flush_last_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (enable && flushStb) |=> ((busyQ & $past(flushMask & relevMask)) == '0));

endmodule

// File: rtl/fb_rearm_ctl.sv
module fb_rearm_ctl
  import fb_rearm_pkg::*;
#(
  parameter int DELAY_TICKS  = 25_000_000,
  parameter int IDLE_TIMEOUT = 12_500_000,
  parameter int CNT_W        = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             active,
  input  logic             idleReady,
  input  logic             flushSeen,
  input  logic             busyNextZero,
  input  logic [CNT_W-1:0] cnt,
  output dpCmd_t           cmd,
  output logic             activateReq
);

  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(IDLE_TIMEOUT - 1);

  rearmState_e stateQ, stateD;
  logic        actQ, actD;

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    actD   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (flushSeen && !active && busyNextZero) begin
          stateD     = ST_DELAY;
          cmd.cntClr = 1'b1;
        end
      end
      ST_DELAY: begin
        if (cnt == DLY_LAST) begin
          stateD     = ST_WAIT;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_WAIT: begin
        if (idleReady) begin
          stateD = ST_IDLE;
          actD   = busyNextZero;
        end else if (cnt == TMO_LAST) begin
          stateD = ST_IDLE;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
    if (!enable) begin
      stateD = ST_IDLE;
      actD   = 1'b0;
      cmd    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      actQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      actQ   <= actD;
    end
  end

  assign activateReq = actQ;

  assert_act_pulse_R5 : assert property (@(posedge clk) disable iff (!rstN)
    activateReq |=> !activateReq);

  assert_cancel_R9 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (stateQ == ST_IDLE && !activateReq));

  assert_giveup_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (enable && stateQ == ST_WAIT && !idleReady && cnt == TMO_LAST)
    |=> (stateQ == ST_IDLE && !activateReq));

  assert_recheck_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && !busyNextZero) |=> !activateReq);

  assert_no_start_active_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && active) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/fb_rearm_ctrl.sv
module fb_rearm_ctrl
  import fb_rearm_pkg::*;
#(
  parameter int PLANES       = 8,
  parameter int DELAY_TICKS  = 25_000_000,
  parameter int IDLE_TIMEOUT = 12_500_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              active,
  input  logic              idleReady,
  input  logic [PLANES-1:0] relevMask,
  input  logic              invStb,
  input  logic [PLANES-1:0] invMask,
  input  logic              flushStb,
  input  logic [PLANES-1:0] flushMask,
  output logic              exitReq,
  output logic              activateReq
);

  localparam int MAX_TICKS = (DELAY_TICKS > IDLE_TIMEOUT) ? DELAY_TICKS : IDLE_TIMEOUT;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  dpCmd_t           cmd;
  logic             flushSeen;
  logic             busyNextZero;
  logic [CNT_W-1:0] cnt;

  fb_rearm_dp #(
    .PLANES(PLANES),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .relevMask   (relevMask),
    .invStb      (invStb),
    .invMask     (invMask),
    .flushStb    (flushStb),
    .flushMask   (flushMask),
    .cmd         (cmd),
    .exitReq     (exitReq),
    .flushSeen   (flushSeen),
    .busyNextZero(busyNextZero),
    .cnt         (cnt)
  );

  fb_rearm_ctl #(
    .DELAY_TICKS (DELAY_TICKS),
    .IDLE_TIMEOUT(IDLE_TIMEOUT),
    .CNT_W       (CNT_W)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .active      (active),
    .idleReady   (idleReady),
    .flushSeen   (flushSeen),
    .busyNextZero(busyNextZero),
    .cnt         (cnt),
    .cmd         (cmd),
    .activateReq (activateReq)
  );

  assert_quiet_off_R11 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!exitReq && !activateReq));

endmodule

// File: tb/tb_fb_rearm_ctrl.sv
module tb_fb_rearm_ctrl;

  localparam int P = 4;
  localparam int D = 20;
  localparam int T = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         active = 1'b0;
  logic         idleReady = 1'b0;
  logic [P-1:0] relev = '0;
  logic         invStb = 1'b0;
  logic [P-1:0] invMask = '0;
  logic         flushStb = 1'b0;
  logic [P-1:0] flushMask = '0;
  logic         exitReq;
  logic         activateReq;

  int checks = 0;
  int fails = 0;
  int actCount = 0;
  int n0;

  always #2 clk = ~clk;

  fb_rearm_ctrl #(.PLANES(P), .DELAY_TICKS(D), .IDLE_TIMEOUT(T)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .active(active),
    .idleReady(idleReady), .relevMask(relev), .invStb(invStb),
    .invMask(invMask), .flushStb(flushStb), .flushMask(flushMask),
    .exitReq(exitReq), .activateReq(activateReq)
  );

  always @(negedge clk) if (activateReq) actCount++;

  // {relev[4], invStb, invMask[4], flushStb, flushMask[4], expExit}
  localparam logic [14:0] VEC [9] = '{
    {4'hF, 1'b1, 4'h1, 1'b0, 4'h0, 1'b1},
    {4'hF, 1'b0, 4'h0, 1'b1, 4'h1, 1'b1},
    {4'h1, 1'b1, 4'h2, 1'b0, 4'h0, 1'b0},
    {4'h1, 1'b1, 4'h3, 1'b0, 4'h0, 1'b1},
    {4'h2, 1'b0, 4'h0, 1'b1, 4'h1, 1'b0},
    {4'h0, 1'b1, 4'hF, 1'b1, 4'hF, 1'b0},
    {4'hC, 1'b1, 4'h4, 1'b1, 4'h8, 1'b1},
    {4'hF, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0},
    {4'hF, 1'b1, 4'h0, 1'b0, 4'h0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic i, input logic [P-1:0] im,
                        input logic f, input logic [P-1:0] fm);
    invStb = i; invMask = im; flushStb = f; flushMask = fm;
    @(negedge clk);
    invStb = 1'b0; invMask = '0; flushStb = 1'b0; flushMask = '0;
  endtask

  task automatic quiesce();
    enable = 1'b0;
    waitN(2);
    enable = 1'b1;
    waitN(1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    waitN(3);
    chk("reset exitReq R2", int'(exitReq), 0);
    chk("reset activateReq R5", int'(activateReq), 0);
    rstN = 1'b1; enable = 1'b1; active = 1'b1; idleReady = 1'b1; relev = 4'hF;
    waitN(1);

    // Table: exit request versus masking (R1, R2, R3)
    for (int i = 0; i < 9; i++) begin
      relev = VEC[i][14:11];
      strobe(VEC[i][10], VEC[i][9:6], VEC[i][5], VEC[i][4:1]);
      chk($sformatf("vector %0d exitReq R1", i), int'(exitReq), int'(VEC[i][0]));
    end
    relev = 4'hF;
    quiesce();
    active = 1'b0;

    // R5: nominal re-arm timing
    strobe(1'b1, 4'h1, 1'b0, 4'h0);
    chk("invalidate exit R2", int'(exitReq), 1);
    strobe(1'b0, 4'h0, 1'b1, 4'h1);
    chk("flush exit R3", int'(exitReq), 1);
    waitN(D);
    chk("activate not early R5", int'(activateReq), 0);
    waitN(1);
    chk("activate due R5", int'(activateReq), 1);
    waitN(1);
    chk("activate one cycle R5", int'(activateReq), 0);

    // R4: second flush does not restart the timer
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(4);
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(D - 5);
    chk("no restart early R4", int'(activateReq), 0);
    waitN(1);
    chk("no restart due R4", int'(activateReq), 1);
    waitN(2);

    // R4: no start while engine active
    active = 1'b1;
    n0 = actCount;
    strobe(1'b0, 4'h0, 1'b1, 4'h1);
    waitN(D + 4);
    chk("no start when active R4", actCount - n0, 0);
    active = 1'b0;

    // R7: dirty plane blocks start
    n0 = actCount;
    strobe(1'b1, 4'h1, 1'b0, 4'h0);
    strobe(1'b0, 4'h0, 1'b1, 4'h2);
    waitN(D + 4);
    chk("busy blocks start R7", actCount - n0, 0);
    quiesce();

    // R7: invalidate during delay blocks activate at expiry
    n0 = actCount;
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(3);
    strobe(1'b1, 4'h4, 1'b0, 4'h0);
    waitN(D + 2);
    chk("recheck at expiry R7", actCount - n0, 0);
    quiesce();

    // R6: idle never arrives in window
    idleReady = 1'b0;
    n0 = actCount;
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(D + T + 2);
    idleReady = 1'b1;
    waitN(3);
    chk("abandon after timeout R6", actCount - n0, 0);

    // R6: idle arrives inside window
    idleReady = 1'b0;
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(D + 3);
    idleReady = 1'b1;
    waitN(1);
    chk("activate on late idle R6", int'(activateReq), 1);
    waitN(2);

    // R9: disable cancels timer
    n0 = actCount;
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(5);
    enable = 1'b0;
    waitN(1);
    enable = 1'b1;
    waitN(D + 4);
    chk("disable cancels R9", actCount - n0, 0);

    // R8: busy cleared across disable
    strobe(1'b1, 4'h1, 1'b0, 4'h0);
    enable = 1'b0;
    waitN(2);
    enable = 1'b1;
    waitN(1);
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    chk("empty flush no exit R3", int'(exitReq), 0);
    waitN(D + 1);
    chk("busy cleared on enable R8", int'(activateReq), 1);
    waitN(2);

    // R11: strobes ignored while disabled
    enable = 1'b0;
    n0 = actCount;
    strobe(1'b1, 4'hF, 1'b0, 4'h0);
    chk("disabled invalidate R11", int'(exitReq), 0);
    strobe(1'b0, 4'h0, 1'b1, 4'hF);
    chk("disabled flush R11", int'(exitReq), 0);
    waitN(D + 4);
    chk("disabled no activate R11", actCount - n0, 0);
    enable = 1'b1;
    waitN(1);

    // R10: same-cycle ordering
    strobe(1'b1, 4'h1, 1'b1, 4'h1);
    chk("same cycle exit R10", int'(exitReq), 1);
    waitN(D + 1);
    chk("same plane ends clean R10", int'(activateReq), 1);
    waitN(2);
    n0 = actCount;
    strobe(1'b1, 4'h2, 1'b1, 4'h1);
    waitN(D + 4);
    chk("other plane stays dirty R10", actCount - n0, 0);
    quiesce();

    // R1: irrelevant plane leaves busy untouched
    relev = 4'h1;
    strobe(1'b1, 4'h2, 1'b0, 4'h0);
    chk("irrelevant invalidate R1", int'(exitReq), 0);
    strobe(1'b0, 4'h0, 1'b1, 4'h0);
    waitN(D + 1);
    chk("irrelevant plane not busy R1", int'(activateReq), 1);
    relev = 4'hF;
    waitN(2);

    finishRun();
  end

endmodule